// File: doc/BRIEF.md
# Serial Management Bus Master with Extended Framing

This block is a management bus master for PHY and switch devices. From the system clock it derives a management clock (MDC) and shifts one complete 64-bit frame per request over a shared bidirectional data line. It drives the data line through separate output and output-enable pins, and the pad ring combines them with the input pin.

A request carries a frame mode, a direction, a PHY address, an 8-bit register number and 16 bits of write data. Mode 0 (and mode 3) sends ordinary clause-22 frames. Mode 1 reaches an 8-bit register space by holding the opcode at 00 and packing the direction and register bits [7:5] into the PHY-address field. Mode 2 also reaches 8-bit registers: it keeps the normal read/write opcodes and spreads register bits [7:5] around two fixed ones in the PHY field. When a read completes, the block presents the 16 captured data bits together with a one-cycle done pulse.

Top module: `mgmt_serial_master`

## Requirements
- R1: Every frame has 64 bits, sent MSB first: 32 ones, the start pattern 01, a 2-bit opcode, a 5-bit PHY field, a 5-bit register field, 2 turnaround bits and 16 data bits. Each bit lasts CLK_DIV system cycles, with MDC low for the first half and high for the second. MDIO changes only when MDC falls.
- R2: In mode 0 or 3 the opcode is 10 for a read and 01 for a write. The PHY field is req_phy and the register field is req_reg[4:0].
- R3: In mode 1 the opcode is 00. The PHY field is {direction (1 = read), 0, req_reg[7:5]} and the register field is req_reg[4:0]. req_phy is not used.
- R4: In mode 2 the opcode is 10 for a read and 01 for a write. The PHY field is {req_reg[7], req_reg[6], 1, 1, req_reg[5]} and the register field is req_reg[4:0]. req_phy is not used.
- R5: On a read, mdio_oe is low from the first turnaround bit (frame bit 46, counting the first preamble bit as bit 0) through the end of the frame. On a write, the turnaround is driven as 1 then 0 and the data phase is driven as well.
- R6: A write in mode 0/3 sends req_wdata[15:0]. A write in mode 1 or 2 sends eight zeros, then req_wdata[7:0].
- R7: On a read, mdio_i is sampled on each MDC rising edge of the 16 data bits, MSB first. The result appears on rdata in the cycle of the done pulse and holds until the next read completes. A write leaves rdata unchanged.
- R8: busy rises in the cycle after a request is accepted. The done pulse is one cycle wide and appears 64*CLK_DIV cycles after the accepting edge, and busy falls at that same edge.
- R9: A request presented while busy is high is ignored. The running frame and its timing are unaffected.
- R10: Out of reset and between frames: mdc low, mdio_oe low, busy low, done low. After reset rdata reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_mode | input | 2 | Frame mode: 0/3 standard, 1 folded, 2 split |
| req_read | input | 1 | 1 = read, 0 = write |
| req_phy | input | 5 | PHY address (standard mode only) |
| req_reg | input | 8 | Register number |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench counts falling-edge clock cycles from the request that was taken. done and rdata must appear exactly 64*CLK_DIV cycles after the accepting edge, and the bench fails the check if they arrive one cycle early or late. Each frame bit is captured at the first falling system-clock edge after MDC rises, which is half a cycle after the change and well before the next MDC fall. The slave model drives read bits half a system cycle after MDC falls, so every value is settled before the rising edge at which the design samples it.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int TA_POS     = 46;   // first turnaround bit
  localparam int DATA_POS   = 48;   // first data bit

  typedef enum logic [1:0] {
    MODE_STD   = 2'd0,
    MODE_FOLD  = 2'd1,
    MODE_SPLIT = 2'd2,
    MODE_STD_B = 2'd3
  } frame_mode_e;
endpackage

// File: rtl/mgmt_clkdiv.sv
module mgmt_clkdiv #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             wrap;

  assign wrap     = run && (cnt_q == CNT_LAST);
  assign rise_stb = wrap && !mdc_q;
  assign fall_stb = wrap && mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (wrap) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mgmt_frame_build.sv
module mgmt_frame_build
  import mgmt_pkg::*;
(
  input  logic [1:0]            mode,
  input  logic                  rd,
  input  logic [4:0]            phy,
  input  logic [7:0]            regn,
  input  logic [DATA_BITS-1:0]  wdata,
  output logic [FRAME_BITS-1:0] frame,
  output logic [FRAME_BITS-1:0] drive
);
  logic [1:0]           op;
  logic [4:0]           phy_f;
  logic [DATA_BITS-1:0] dat;

  always_comb begin
    op    = rd ? 2'b10 : 2'b01;
    phy_f = phy;
    dat   = wdata;
    case (frame_mode_e'(mode))
      MODE_FOLD: begin
        op    = 2'b00;
        phy_f = {rd, 1'b0, regn[7:5]};
        dat   = {8'h00, wdata[7:0]};
      end
      MODE_SPLIT: begin
        phy_f = {regn[7], regn[6], 2'b11, regn[5]};
        dat   = {8'h00, wdata[7:0]};
      end
      default: ;
    endcase
    if (rd) dat = '0;
    frame = {{32{1'b1}}, 2'b01, op, phy_f, regn[4:0],
             (rd ? 2'b00 : 2'b10), dat};
    drive = {{TA_POS{1'b1}}, {(FRAME_BITS-TA_POS){!rd}}};
  end
endmodule

// File: rtl/mgmt_rd_capture.sv
module mgmt_rd_capture
  import mgmt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 din,
  input  logic                 load,
  output logic [DATA_BITS-1:0] rdata
);
  logic [DATA_BITS-1:0] sh_q, sh_d, out_q, out_d;

  always_comb begin
    sh_d  = shift_en ? {sh_q[DATA_BITS-2:0], din} : sh_q;
    out_d = load ? sh_q : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= '0;
    end else begin
      sh_q  <= sh_d;
      out_q <= out_d;
    end
  end

  assign rdata = out_q;
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
  import mgmt_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [1:0]           req_mode,
  input  logic                 req_read,
  input  logic [4:0]           req_phy,
  input  logic [7:0]           req_reg,
  input  logic [DATA_BITS-1:0] req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_BITS-1:0] rdata,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  input  logic                 mdio_i
);
  localparam int IDX_W = $clog2(FRAME_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_POS);

  logic                  busy_q, busy_d, done_q, done_d, rd_q, rd_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] tx_q, tx_d, oe_q, oe_d;
  logic [FRAME_BITS-1:0] frame_w, drive_w;
  logic                  rise_stb, fall_stb, accept, last_fall;

  mgmt_clkdiv #(.CLK_DIV(CLK_DIV)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(busy_q),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mgmt_frame_build u_build (
    .mode(req_mode), .rd(req_read), .phy(req_phy), .regn(req_reg),
    .wdata(req_wdata), .frame(frame_w), .drive(drive_w)
  );

  assign accept    = req_valid && !busy_q;
  assign last_fall = busy_q && fall_stb && (idx_q == IDX_LAST);

  mgmt_rd_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .shift_en(busy_q && rise_stb && rd_q && (idx_q >= IDX_DATA)),
    .din(mdio_i),
    .load(last_fall && rd_q),
    .rdata(rdata)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    rd_d   = rd_q;
    idx_d  = idx_q;
    tx_d   = tx_q;
    oe_d   = oe_q;
    if (accept) begin
      busy_d = 1'b1;
      rd_d   = req_read;
      idx_d  = '0;
      tx_d   = frame_w;
      oe_d   = drive_w;
    end else if (last_fall) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      tx_d   = '0;
      oe_d   = '0;
    end else if (busy_q && fall_stb) begin
      idx_d  = idx_q + 1'b1;
      tx_d   = tx_q << 1;
      oe_d   = oe_q << 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      tx_q   <= '0;
      oe_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      rd_q   <= rd_d;
      idx_q  <= idx_d;
      tx_q   <= tx_d;
      oe_q   <= oe_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign mdio_o  = tx_q[FRAME_BITS-1];
  assign mdio_oe = oe_q[FRAME_BITS-1];
endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

  // R1
  mdio_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mgmt_serial_master mgmt_serial_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .done(done), .rdata(rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mgmt_serial_master_tb.sv
module mgmt_serial_master_tb;
  localparam int DIV = 4;
  localparam int FRAME_CYC = 64 * DIV;

  logic        clk, rst_n;
  logic        req_valid, req_read, mdio_i;
  logic [1:0]  req_mode;
  logic [4:0]  req_phy;
  logic [7:0]  req_reg;
  logic [15:0] req_wdata;
  logic        busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] exp_rdata = 16'h0;

  mgmt_serial_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_read(req_read), .req_phy(req_phy), .req_reg(req_reg),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = !clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected frame bits, index 0 is the first bit on the wire.
  function automatic logic [63:0] exp_frame(input logic [1:0] m, input logic rd,
      input logic [4:0] p, input logic [7:0] r, input logic [15:0] w);
    logic [63:0] f;
    f = '0;
    for (int i = 0; i < 32; i++) f[63-i] = 1'b1;
    f[63-33] = 1'b1;                       // start 0,1
    if (m == 2'd1) begin                   // R3
      f[63-36] = rd; f[63-37] = 1'b0;
      f[63-38] = r[7]; f[63-39] = r[6]; f[63-40] = r[5];
    end else begin
      f[63-34] = rd; f[63-35] = !rd;       // R2 / R4 opcode
      if (m == 2'd2) begin                 // R4
        f[63-36] = r[7]; f[63-37] = r[6]; f[63-38] = 1'b1;
        f[63-39] = 1'b1; f[63-40] = r[5];
      end else begin
        for (int i = 0; i < 5; i++) f[63-36-i] = p[4-i];
      end
    end
    for (int i = 0; i < 5; i++) f[63-41-i] = r[4-i];
    if (!rd) begin
      f[63-46] = 1'b1;                     // R5 turnaround 1,0
      for (int i = 0; i < 16; i++)
        f[63-48-i] = ((m == 2'd1 || m == 2'd2) && i < 8) ? 1'b0 : w[15-i];
    end
    return f;
  endfunction

  function automatic logic [63:0] exp_drive(input logic rd);
    logic [63:0] d;
    for (int i = 0; i < 64; i++) d[63-i] = (i < 46) ? 1'b1 : !rd;
    return d;
  endfunction

  task automatic xfer(input logic [1:0] m, input logic rd, input logic [4:0] p,
                      input logic [7:0] r, input logic [15:0] w,
                      input logic [15:0] sdata, input bit poke);
    logic [63:0] cap, capoe, ef, ed;
    int n, cbit;
    logic prev_mdc;
    bit got, busy_ok;
    cap = '0; capoe = '0; cbit = 0; got = 0; busy_ok = 1;
    @(negedge clk);
    req_mode = m; req_read = rd; req_phy = p; req_reg = r; req_wdata = w;
    req_valid = 1'b1; mdio_i = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    prev_mdc = mdc;
    n = 0;
    while (!got && n < FRAME_CYC + 8) begin
      @(negedge clk);
      n++;
      if (poke && n == 100) begin         // R9 request during busy
        req_mode = ~m; req_read = !rd; req_phy = ~p; req_reg = ~r;
        req_wdata = ~w; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (mdc && !prev_mdc && cbit < 64) begin
        cap[63-cbit] = mdio_o; capoe[63-cbit] = mdio_oe;
        cbit++;
      end
      if (!mdc && prev_mdc) begin
        if (cbit == 47) mdio_i = 1'b0;
        else if (cbit >= 48 && cbit < 64) mdio_i = sdata[63-cbit];
        else mdio_i = 1'b1;
      end
      prev_mdc = mdc;
      if (done) got = 1;
      else if (!busy) busy_ok = 0;
    end
    ef = exp_frame(m, rd, p, r, w);
    ed = exp_drive(rd);
    check(got && n == FRAME_CYC, "R8 done latency", 64'(n), 64'(FRAME_CYC));
    check(busy_ok, "R8 busy held during frame", 64'(busy_ok), 64'd1);
    check(cbit == 64, "R1 bit count", 64'(cbit), 64'd64);
    check((cap & ed) == (ef & ed), $sformatf("R1 R2 R3 R4 R6 frame mode=%0d rd=%0d", m, rd),
          cap & ed, ef & ed);
    check(capoe == ed, "R5 output enable pattern", capoe, ed);
    if (rd) exp_rdata = sdata;
    check(rdata == exp_rdata, "R7 read data", 64'(rdata), 64'(exp_rdata));
    if (poke) check(!busy, "R9 busy request ignored", 64'(busy), 64'd0);
    @(negedge clk);
    check(!done && !busy && !mdc && !mdio_oe, "R10 idle after frame",
          {60'd0, done, busy, mdc, mdio_oe}, 64'd0);
    check(rdata == exp_rdata, "R7 rdata held", 64'(rdata), 64'(exp_rdata));
  endtask

  initial begin
    while (1) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; req_valid = 1'b0; req_read = 1'b0; req_mode = 2'd0;
    req_phy = '0; req_reg = '0; req_wdata = '0; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !mdc && !mdio_oe && rdata == 16'h0,
          "R10 reset state", {43'd0, busy, done, mdc, mdio_oe, rdata}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !mdc && !mdio_oe, "R10 idle after reset",
          {61'd0, busy, mdc, mdio_oe}, 64'd0);
    // directed corner cases
    xfer(2'd0, 1'b1, 5'h1F, 8'h1F, 16'h0, 16'hA5C3, 1'b0);   // R2 read
    xfer(2'd0, 1'b0, 5'h00, 8'h00, 16'hFFFF, 16'h0, 1'b0);   // R2 write, R7 kept
    xfer(2'd1, 1'b1, 5'h15, 8'hE0, 16'h0, 16'h00FF, 1'b0);   // R3 read
    xfer(2'd1, 1'b0, 5'h0A, 8'hA7, 16'hBEEF, 16'h0, 1'b0);   // R3 write, R6
    xfer(2'd2, 1'b1, 5'h00, 8'h5A, 16'h0, 16'h0081, 1'b0);   // R4 read
    xfer(2'd2, 1'b0, 5'h1F, 8'hFF, 16'h1234, 16'h0, 1'b0);   // R4 write
    xfer(2'd3, 1'b0, 5'h11, 8'h33, 16'h8001, 16'h0, 1'b1);   // R2 mode 3, R9
    xfer(2'd1, 1'b1, 5'h04, 8'h01, 16'h0, 16'h0000, 1'b1);   // R9 on read
    // constrained random
    for (int t = 0; t < 30; t++) begin
      xfer(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           5'($urandom), 8'($urandom), 16'($urandom), 16'($urandom), 1'b0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule